// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device-side owner of a circular ring of receive buffer descriptors. The host tells it how far the ring has been stocked by writing a write index, which names the next descriptor the host will supply. As frame data lands in the current buffer (modelled as one pulse per chunk written, with an end-of-frame flag), the block counts the chunks. It closes the buffer when the buffer is full, or when no chunk has arrived for a programmable number of 32 µs ticks. It then advances its own fill index and publishes the index of the buffer it just closed. An interrupt pulse goes to the host when the interrupt destination selects it.

Configuration comes in as static inputs: a channel mode (stop, stop after the current frame, run), a ring-size exponent, a buffer-size code, an interrupt destination and a close timeout. The block reports an idle flag in its status word whenever it is not accepting data. Actual memory transfers are outside the block.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After synchronous reset, stat_o reads 0x0100_0000 (index 0, idle bit 24 set), and close_o, irq_o and widx_err_o are 0.
- R2: The ring holds 2^E descriptors, where E is cfg_ring_exp clamped to the range 5..12. All indices wrap modulo 2^E, so the published index returns to 0 after index 2^E-1, and it never exceeds 2^E-1.
- R3: A host_widx_wr with host_widx a multiple of 8 stores host_widx modulo the ring size. A write whose host_widx has any of bits [2:0] set is discarded, and widx_err_o is high for exactly the cycle after it.
- R4: When the fill index equals the stored host write index there is no room, and frm_wr pulses are ignored: no chunk is counted and no buffer closes.
- R5: A buffer holds (cfg_buf_code+1)*CHUNKS_4K chunks (codes 0..3 are 4K, 8K, 12K, 16K bytes). The accepted frm_wr that fills it closes it: close_o is high in the following cycle, and stat_o[11:0] then shows the index of the closed buffer.
- R6: While accepting, with a partly filled buffer and cfg_timeout=T not 0, the buffer closes on the T-th tick_32us pulse after the last accepted chunk. A tick in the same cycle as an accepted chunk is not counted. T=0 disables the timeout.
- R7: irq_o pulses together with close_o when cfg_irq_dst is 01. For any other value it stays 0.
- R8: cfg_mode 10 accepts chunks. cfg_mode 00 and 11 accept none.
- R9: With cfg_mode 01, chunks are accepted only while a frame is in progress (a frame starts with an accepted chunk without frm_eof). Acceptance ends after the accepted chunk carrying frm_eof.
- R10: stat_o bit 24 is 1 in the cycle after any edge at which the channel will not accept chunks in the next cycle, and 0 otherwise.
- R11: The timeout count holds its value while the channel is not accepting, and it resumes when acceptance resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Channel mode: 00 stop, 01 stop at end of frame, 10 run, 11 stop |
| cfg_ring_exp | input | EXP_W | Ring size exponent |
| cfg_buf_code | input | 2 | Buffer size code |
| cfg_irq_dst | input | 2 | Interrupt destination, 01 = host |
| cfg_timeout | input | TMO_W | Close timeout in ticks, 0 = off |
| host_widx_wr | input | 1 | Host write index update strobe |
| host_widx | input | IDX_W | Host write index value |
| tick_32us | input | 1 | Timeout time base pulse |
| frm_wr | input | 1 | One chunk written to the current buffer |
| frm_eof | input | 1 | The chunk ends a frame |
| close_o | output | 1 | Buffer closed (one-cycle pulse) |
| irq_o | output | 1 | Host interrupt pulse |
| widx_err_o | output | 1 | Misaligned host index rejected |
| stat_o | output | 32 | [IDX_W-1:0] last closed index, [24] idle |

## Verification
A wrong fill or host index shows up as a missing or extra close_o, visible at the first chunk after the ring should have run out of room or regained it. A wrong wrap shows up as a stat_o index outside the ring, or as a failure to return to 0. A wrong chunk count or timer moves the close_o pulse by at least one cycle, at the end of the first buffer affected. A wrong frame state under end-of-frame stopping flips the idle bit and the acceptance of the next chunk in the cycle that follows.

// File: rtl/rx_ring_pkg.sv
`timescale 1ns/1ps
package rx_ring_pkg;

    typedef enum logic [1:0] {
        CH_STOP     = 2'b00,
        CH_STOP_EOF = 2'b01,
        CH_RUN      = 2'b10,
        CH_RSVD     = 2'b11
    } ch_mode_e;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_HOST = 2'b01,
        IRQ_RES2 = 2'b10,
        IRQ_RES3 = 2'b11
    } irq_dst_e;

    localparam int STAT_IDLE_BIT = 24;

    // Mask of the index bits that belong to a ring of 2^e entries,
    // with e clamped to [emin, emax].
    function automatic logic [31:0] ring_mask(input int e, input int emin, input int emax);
        int ec;
        ec = e;
        if (ec < emin) ec = emin;
        if (ec > emax) ec = emax;
        for (int i = 0; i < 32; i++) ring_mask[i] = (i < ec);
    endfunction

    function automatic logic run_mode(input ch_mode_e m, input logic in_frame);
        return (m == CH_RUN) || ((m == CH_STOP_EOF) && in_frame);
    endfunction

endpackage

// File: rtl/rx_ring_ptr.sv
`timescale 1ns/1ps
module rx_ring_ptr
    import rx_ring_pkg::*;
#(
    parameter int IDX_W     = 12,
    parameter int EXP_MIN   = 5,
    parameter int WIDX_STEP = 8,
    localparam int EXP_W    = $clog2(IDX_W + 1),
    localparam int STEP_LSB = $clog2(WIDX_STEP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] ring_exp,
    input  logic             widx_wr,
    input  logic [IDX_W-1:0] widx_in,
    input  logic             close_now,
    output logic             room,
    output logic [IDX_W-1:0] last_idx,
    output logic             widx_err
);
    logic [31:0]      mask_full;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] widx_q;
    logic [IDX_W-1:0] fill_q;
    logic             misaligned;

    assign mask_full  = ring_mask(int'(ring_exp), EXP_MIN, IDX_W);
    assign mask       = mask_full[IDX_W-1:0];
    assign misaligned = |widx_in[STEP_LSB-1:0];
    assign room       = (fill_q & mask) != (widx_q & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            widx_q   <= '0;
            fill_q   <= '0;
            last_idx <= '0;
            widx_err <= 1'b0;
        end else begin
            widx_err <= widx_wr && misaligned;
            if (widx_wr && !misaligned) widx_q <= widx_in & mask;
            if (close_now) begin
                last_idx <= fill_q & mask;
                fill_q   <= (fill_q + 1'b1) & mask;
            end
        end
    end
endmodule

// File: rtl/rx_buf_fill.sv
`timescale 1ns/1ps
module rx_buf_fill
    import rx_ring_pkg::*;
#(
    parameter int CHUNKS_4K = 4,
    parameter int TMO_W     = 8,
    localparam int CNT_W    = $clog2(4 * CHUNKS_4K + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             eof,
    input  logic             tick,
    input  logic             run,
    input  logic [1:0]       buf_code,
    input  logic [TMO_W-1:0] tmo,
    output logic             close_now,
    output logic             in_frame_q,
    output logic             in_frame_d
);
    logic [CNT_W-1:0] cap_tab [4];
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] chunks_q;
    logic [CNT_W-1:0] ch_inc;
    logic [TMO_W-1:0] tmr_q;
    logic [TMO_W:0]   tmr_inc;
    logic             tmo_arm;
    logic             full_hit;
    logic             tmo_hit;

    for (genvar g = 0; g < 4; g++) begin : g_cap
        assign cap_tab[g] = CNT_W'((g + 1) * CHUNKS_4K);
    end

    assign cap        = cap_tab[buf_code];
    assign ch_inc     = chunks_q + 1'b1;
    assign tmr_inc    = {1'b0, tmr_q} + 1'b1;
    assign tmo_arm    = run && tick && (chunks_q != '0) && (tmo != '0);
    assign full_hit   = acc && (ch_inc >= cap);
    assign tmo_hit    = !acc && tmo_arm && (tmr_inc == {1'b0, tmo});
    assign close_now  = full_hit || tmo_hit;
    assign in_frame_d = acc ? !eof : in_frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chunks_q   <= '0;
            tmr_q      <= '0;
            in_frame_q <= 1'b0;
        end else begin
            in_frame_q <= in_frame_d;
            if (close_now) begin
                chunks_q <= '0;
                tmr_q    <= '0;
            end else if (acc) begin
                chunks_q <= ch_inc;
                tmr_q    <= '0;
            end else if (tmo_arm) begin
                tmr_q <= tmr_inc[TMO_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rx_chan_ctl.sv
`timescale 1ns/1ps
module rx_chan_ctl
    import rx_ring_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ch_mode_e mode,
    input  logic     in_frame_q,
    input  logic     in_frame_d,
    output logic     run,
    output logic     idle_q
);
    assign run = run_mode(mode, in_frame_q);

    always_ff @(posedge clk) begin
        if (rst) idle_q <= 1'b1;
        else     idle_q <= !run_mode(mode, in_frame_d);
    end
endmodule

// File: rtl/rx_ring_ctrl.sv
`timescale 1ns/1ps
module rx_ring_ctrl
    import rx_ring_pkg::*;
#(
    parameter int IDX_W     = 12,
    parameter int EXP_MIN   = 5,
    parameter int WIDX_STEP = 8,
    parameter int CHUNKS_4K = 4,
    parameter int TMO_W     = 8,
    localparam int EXP_W    = $clog2(IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic [EXP_W-1:0] cfg_ring_exp,
    input  logic [1:0]       cfg_buf_code,
    input  logic [1:0]       cfg_irq_dst,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             host_widx_wr,
    input  logic [IDX_W-1:0] host_widx,
    input  logic             tick_32us,
    input  logic             frm_wr,
    input  logic             frm_eof,
    output logic             close_o,
    output logic             irq_o,
    output logic             widx_err_o,
    output logic [31:0]      stat_o
);
    ch_mode_e         mode;
    irq_dst_e         dst;
    logic             room;
    logic             run;
    logic             acc;
    logic             close_now;
    logic             in_frame_q;
    logic             in_frame_d;
    logic             idle_q;
    logic [IDX_W-1:0] last_idx;

    assign mode = ch_mode_e'(cfg_mode);
    assign dst  = irq_dst_e'(cfg_irq_dst);
    assign acc  = frm_wr && room && run;

    rx_ring_ptr #(
        .IDX_W(IDX_W), .EXP_MIN(EXP_MIN), .WIDX_STEP(WIDX_STEP)
    ) u_ptr (
        .clk(clk), .rst(rst), .ring_exp(cfg_ring_exp),
        .widx_wr(host_widx_wr), .widx_in(host_widx),
        .close_now(close_now), .room(room),
        .last_idx(last_idx), .widx_err(widx_err_o)
    );

    rx_buf_fill #(
        .CHUNKS_4K(CHUNKS_4K), .TMO_W(TMO_W)
    ) u_fill (
        .clk(clk), .rst(rst), .acc(acc), .eof(frm_eof),
        .tick(tick_32us), .run(run), .buf_code(cfg_buf_code),
        .tmo(cfg_timeout), .close_now(close_now),
        .in_frame_q(in_frame_q), .in_frame_d(in_frame_d)
    );

    rx_chan_ctl u_ctl (
        .clk(clk), .rst(rst), .mode(mode),
        .in_frame_q(in_frame_q), .in_frame_d(in_frame_d),
        .run(run), .idle_q(idle_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            close_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            close_o <= close_now;
            irq_o   <= close_now && (dst == IRQ_HOST);
        end
    end

    always_comb begin
        stat_o                = '0;
        stat_o[IDX_W-1:0]     = last_idx;
        stat_o[STAT_IDLE_BIT] = idle_q;
    end
endmodule

// File: rtl/rx_ring_ctrl_chk.sv
`timescale 1ns/1ps
module rx_ring_ctrl_chk
    import rx_ring_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int EXP_MIN = 5,
    localparam int EXP_W  = $clog2(IDX_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [EXP_W-1:0] cfg_ring_exp,
    input logic             host_widx_wr,
    input logic             tick_32us,
    input logic             frm_wr,
    input logic             close_o,
    input logic             irq_o,
    input logic             widx_err_o,
    input logic [31:0]      stat_o
);
    logic [31:0] mask_full;
    assign mask_full = ring_mask(int'(cfg_ring_exp), EXP_MIN, IDX_W);

    // R7
    irq_with_close_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> close_o);

    // R3
    widx_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        widx_err_o |-> $past(host_widx_wr));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !close_o |-> $stable(stat_o[IDX_W-1:0]));

    // R6
    close_cause_chk: assert property (@(posedge clk) disable iff (rst)
        close_o |-> $past(frm_wr || tick_32us));

    // R2
    idx_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_o[IDX_W-1:0] & ~mask_full[IDX_W-1:0]) == '0);
endmodule

bind rx_ring_ctrl rx_ring_ctrl_chk #(.IDX_W(IDX_W), .EXP_MIN(EXP_MIN)) u_chk (
    .clk(clk), .rst(rst), .cfg_ring_exp(cfg_ring_exp),
    .host_widx_wr(host_widx_wr), .tick_32us(tick_32us), .frm_wr(frm_wr),
    .close_o(close_o), .irq_o(irq_o), .widx_err_o(widx_err_o), .stat_o(stat_o)
);

// File: tb/test_rx_ring_ctrl.sv
`timescale 1ns/1ps
module test_rx_ring_ctrl;
    localparam int IDX_W = 12;
    localparam int CH4K  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'b00;
    logic [3:0]  cfg_ring_exp = 4'd8;
    logic [1:0]  cfg_buf_code = 2'b00;
    logic [1:0]  cfg_irq_dst = 2'b01;
    logic [7:0]  cfg_timeout = 8'd0;
    logic        host_widx_wr = 1'b0;
    logic [11:0] host_widx = '0;
    logic        tick_32us = 1'b0;
    logic        frm_wr = 1'b0;
    logic        frm_eof = 1'b0;
    logic        close_o, irq_o, widx_err_o;
    logic [31:0] stat_o;

    int checks = 0;
    int errors = 0;

    // bench model state
    int m_widx, m_fill, m_last, m_ch, m_tmr;
    bit m_inf;
    bit e_close, e_irq, e_err, e_idle;

    always #10 clk = ~clk;

    rx_ring_ctrl i_rx_ring_ctrl (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_ring_exp(cfg_ring_exp),
        .cfg_buf_code(cfg_buf_code), .cfg_irq_dst(cfg_irq_dst),
        .cfg_timeout(cfg_timeout), .host_widx_wr(host_widx_wr),
        .host_widx(host_widx), .tick_32us(tick_32us), .frm_wr(frm_wr),
        .frm_eof(frm_eof), .close_o(close_o), .irq_o(irq_o),
        .widx_err_o(widx_err_o), .stat_o(stat_o)
    );

    function automatic int mask_of(input int e);
        int ec = e;
        if (ec < 5) ec = 5;
        if (ec > 12) ec = 12;
        return (1 << ec) - 1;
    endfunction

    function automatic bit runs(input int md, input bit inf);
        return (md == 2) || (md == 1 && inf);
    endfunction

    task automatic model_reset();
        m_widx = 0; m_fill = 0; m_last = 0; m_ch = 0; m_tmr = 0; m_inf = 0;
        e_close = 0; e_irq = 0; e_err = 0; e_idle = 1;
    endtask

    task automatic model_step();
        int mk, cap;
        bit run, room, acc, cl;
        mk   = mask_of(int'(cfg_ring_exp));
        run  = runs(int'(cfg_mode), m_inf);
        room = (m_fill & mk) != (m_widx & mk);
        acc  = frm_wr && run && room;
        cap  = (int'(cfg_buf_code) + 1) * CH4K;
        cl   = 0;
        if (acc) begin
            if (m_ch + 1 >= cap) cl = 1;
            else begin m_ch = m_ch + 1; m_tmr = 0; end
            m_inf = !frm_eof;
        end else if (tick_32us && run && m_ch != 0 && cfg_timeout != 0) begin
            if (m_tmr + 1 == int'(cfg_timeout)) cl = 1;
            else m_tmr = m_tmr + 1;
        end
        if (cl) begin
            m_last = m_fill & mk;
            m_fill = (m_fill + 1) & mk;
            m_ch = 0; m_tmr = 0;
        end
        e_err = 0;
        if (host_widx_wr) begin
            if (host_widx[2:0] != 0) e_err = 1;
            else m_widx = int'(host_widx) & mk;
        end
        e_close = cl;
        e_irq   = cl && (cfg_irq_dst == 2'b01);
        e_idle  = !runs(int'(cfg_mode), m_inf);
    endtask

    task automatic compare(input string tag);
        logic [31:0] es;
        es = 32'(m_last) | (e_idle ? 32'h0100_0000 : 32'h0);
        checks++;
        if (stat_o !== es || close_o !== e_close || irq_o !== e_irq || widx_err_o !== e_err) begin
            errors++;
            $display("FAIL %s: stat=%h close=%b irq=%b err=%b, expected stat=%h close=%b irq=%b err=%b",
                     tag, stat_o, close_o, irq_o, widx_err_o, es, e_close, e_irq, e_err);
        end
    endtask

    // called at a negedge: drive, model, advance one edge, compare
    task automatic step(input bit w, input bit eof, input bit t, input bit hw,
                        input logic [11:0] hv, input string tag);
        frm_wr = w; frm_eof = eof; tick_32us = t; host_widx_wr = hw; host_widx = hv;
        model_step();
        @(posedge clk);
        @(negedge clk);
        frm_wr = 0; frm_eof = 0; tick_32us = 0; host_widx_wr = 0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        compare("R1 reset");
    endtask

    task automatic chunks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 12'd0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R8: stopped channel takes nothing
        step(0, 0, 0, 1, 12'd8, "R8 widx");
        cfg_mode = 2'b00; chunks(6, "R8 mode00");
        cfg_mode = 2'b11; chunks(6, "R8 mode11");

        // R5: buffer sizes 4K and 16K
        cfg_mode = 2'b10; cfg_buf_code = 2'b00; chunks(4, "R5 cap4");
        cfg_buf_code = 2'b11; chunks(16, "R5 cap16");
        cfg_buf_code = 2'b01; chunks(8, "R5 cap8");

        // R4: ring runs out of room at index 8
        cfg_buf_code = 2'b00; chunks(4 * 5, "R4 fill");
        chunks(8, "R4 noroom");

        // R3: misaligned index rejected, aligned one opens room
        step(0, 0, 0, 1, 12'd12, "R3 misaligned");
        chunks(4, "R3 still noroom");
        step(0, 0, 0, 1, 12'd16, "R3 aligned");
        chunks(4, "R3 room");

        // R6: timeout close, and disabled with 0
        cfg_buf_code = 2'b11; cfg_timeout = 8'd3;
        step(1, 0, 1, 0, 12'd0, "R6 chunk+tick");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 12'd0, "R6 tick");
        cfg_timeout = 8'd0;
        step(1, 0, 0, 0, 12'd0, "R6 chunk");
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 12'd0, "R6 off");

        // R7: no interrupt unless destination is host
        cfg_irq_dst = 2'b00; cfg_buf_code = 2'b00; cfg_timeout = 8'd2;
        chunks(3, "R7 nodst");
        for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 12'd0, "R7 nodst tick");
        cfg_irq_dst = 2'b10; chunks(4, "R7 dst2");
        cfg_irq_dst = 2'b01;

        // R11: timer frozen while stopped
        step(0, 0, 0, 1, 12'd40, "R11 widx");
        step(1, 0, 0, 0, 12'd0, "R11 chunk");
        step(0, 0, 1, 0, 12'd0, "R11 tick1");
        cfg_mode = 2'b00;
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 12'd0, "R11 frozen");
        cfg_mode = 2'b10;
        step(0, 0, 1, 0, 12'd0, "R11 resume");

        // R9, R10: stop at end of frame
        cfg_buf_code = 2'b11; cfg_timeout = 8'd0;
        step(1, 0, 0, 0, 12'd0, "R9 start frame");
        cfg_mode = 2'b01;
        step(1, 0, 0, 0, 12'd0, "R9 R10 mid frame");
        step(1, 1, 0, 0, 12'd0, "R9 R10 eof");
        chunks(3, "R9 R10 after eof");
        step(1, 0, 0, 0, 12'd0, "R9 ignored");
        cfg_mode = 2'b00;
        step(0, 0, 0, 0, 12'd0, "R10 stop");
        cfg_mode = 2'b10;
        step(0, 0, 0, 0, 12'd0, "R10 run");

        // R2: 32-entry ring wraps to 0
        cfg_ring_exp = 4'd5; cfg_buf_code = 2'b00;
        do_reset();
        for (int b = 0; b < 36; b++) begin
            if (b % 8 == 0) step(0, 0, 0, 1, 12'(((b + 8) % 32)), "R2 widx");
            chunks(4, "R2 wrap");
        end
        checks++;
        if (m_last != 3 || stat_o[11:0] !== 12'd3) begin
            errors++;
            $display("FAIL R2 wrap: idx=%0d expected 3", stat_o[11:0]);
        end

        // random phases with clamped exponents
        for (int ph = 0; ph < 4; ph++) begin
            cfg_ring_exp = (ph == 0) ? 4'd3 : (ph == 1) ? 4'd15 : (ph == 2) ? 4'd5 : 4'd8;
            cfg_mode = 2'b10;
            do_reset();
            for (int i = 0; i < 1500; i++) begin
                int r;
                logic [11:0] hv;
                r = $urandom_range(0, 99);
                if (r < 3) cfg_mode = 2'($urandom_range(0, 3));
                else if (r < 10) cfg_mode = 2'b10;
                if ($urandom_range(0, 199) == 0) cfg_buf_code = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 99) == 0) cfg_timeout = 8'($urandom_range(0, 6));
                if ($urandom_range(0, 99) == 0) cfg_irq_dst = 2'($urandom_range(0, 3));
                hv = 12'($urandom_range(0, 4095));
                if ($urandom_range(0, 3) != 0) hv[2:0] = 3'b000;
                step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 3,
                     $urandom_range(0, 9) < 2, $urandom_range(0, 19) == 0, hv,
                     "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule